// File: doc/BRIEF.md
# Message Object Transfer Interface

This block sits between a host register port and a small on-chip RAM of message objects for a CAN controller. The host never touches the RAM directly. It fills a set of staging registers (arbitration, acceptance mask, message control and four 16-bit data words), selects which field groups to move and in which direction, and then starts the transfer by writing the object number. A sequencer copies the chosen groups one per cycle, either from staging into the chosen object or from the object back into staging. While the copy runs, a busy flag is visible in the command request register.

Transfers can also change flags as a side effect. A write can force the transmit request of the object. A read can clear the object's interrupt-pending and new-data flags once they have been copied out. Two 32-bit summaries are kept alongside the RAM, one of the message-valid bits and one of the new-data bits. The host reads each of them as a pair of 16-bit registers.

Top module: `can_msgobj_xfer`

## Requirements
- R1: After reset, the command request register (address 10) reads 0, with the busy flag (bit 15) clear. The command mask (address 9) and all four summary registers (addresses 11 to 14) also read 0.
- R2: A write to address 10 starts a transfer for the object numbered in bits 5:0 of the written value. Busy (bit 15 of address 10) is seen as 1 by the 6 register reads sampled on the 6 clock edges that follow the write, and as 0 from the 7th. Bits 5:0 of the register read back the number.
- R3: With command mask bit 7 = 1, the write direction, staging is copied into the object, but only for the selected groups. The groups are mask (bit 6, addresses 2/3), arbitration (bit 5, addresses 0/1), control (bit 4, address 4), data A (bit 1, addresses 5/6) and data B (bit 0, addresses 7/8). Groups that are not selected keep their old contents in the object.
- R4: With command mask bit 7 = 0, the read direction, only the selected groups are loaded from the object into staging. Other staging registers keep their values.
- R5: A write-direction transfer with command mask bit 2 set sets the object's transmit request (control bit 8), even when the control group is not selected. The object's other control bits are kept.
- R6: A read-direction transfer with command mask bit 3 set clears the object's interrupt-pending flag (control bit 13). Staging receives the value from before the clear.
- R7: A read-direction transfer with command mask bit 2 set clears the object's new-data flag (control bit 15) in the object and in the new-data summary.
- R8: The message-valid summary holds bit 15 of the high arbitration word of each object, taken from its last write. Objects 0 to 15 are in address 11 and objects 16 to 31 are in address 12, with bit i of a register standing for object i (or 16+i).
- R9: The new-data summary holds control bit 15 of each object, from its last control write. Objects 0 to 15 are in address 13 and objects 16 to 31 are in address 14.
- R10: While busy, every host register write is ignored. This covers staging, the command mask and a new command request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the address presented in the previous cycle |

## Verification
A write sampled on edge E0 raises busy on that edge. Because read data is registered, reads sampled on E1 to E6 show busy and the read sampled on E7 shows it clear. The bench checks each of those seven edges by issuing back-to-back reads. The five field groups are committed on E2 to E6. Every functional check therefore waits eight cycles after the command before it reads staging or the summaries, and reads are sampled at the falling edge after the rising edge that registered them.

// File: rtl/can_xfer_pkg.sv
package can_xfer_pkg;
  localparam int NGRP = 5;
  localparam int G_MASK = 0;
  localparam int G_ARB  = 1;
  localparam int G_CTRL = 2;
  localparam int G_DA   = 3;
  localparam int G_DB   = 4;

  localparam int CM_DB     = 0;
  localparam int CM_DA     = 1;
  localparam int CM_AUX    = 2;
  localparam int CM_CLRINT = 3;
  localparam int CM_CTRL   = 4;
  localparam int CM_ARB    = 5;
  localparam int CM_MASK   = 6;
  localparam int CM_WR     = 7;

  localparam int CT_TXRQ   = 8;
  localparam int CT_INTPND = 13;
  localparam int CT_NEWDAT = 15;
  localparam int AR_MSGVAL = 15;

  typedef enum logic [3:0] {
    RA_ARB_LO = 4'd0, RA_ARB_HI = 4'd1, RA_MSK_LO = 4'd2, RA_MSK_HI = 4'd3,
    RA_CTRL   = 4'd4, RA_DA_LO  = 4'd5, RA_DA_HI  = 4'd6, RA_DB_LO  = 4'd7,
    RA_DB_HI  = 4'd8, RA_CMASK  = 4'd9, RA_CREQ   = 4'd10, RA_VAL_LO = 4'd11,
    RA_VAL_HI = 4'd12, RA_ND_LO = 4'd13, RA_ND_HI = 4'd14
  } reg_addr_e;
endpackage

// File: rtl/can_obj_ram.sv
module can_obj_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/can_obj_bitmap.sv
module can_obj_bitmap #(
  parameter int NUM_OBJ = 32,
  localparam int IDXW   = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic [IDXW-1:0]    idx,
  input  logic               val,
  output logic [NUM_OBJ-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else if (upd) bits[idx] <= val;
  end
endmodule

// File: rtl/can_xfer_seq.sv
module can_xfer_seq #(
  parameter int NUM_W = 6,
  parameter int NGRP  = 5,
  localparam int SW   = $clog2(NGRP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       cmd_mask_in,
  input  logic [NUM_W-1:0] cmd_num_in,
  output logic             busy,
  output logic [NUM_W-1:0] num_q,
  output logic [7:0]       mask_q,
  output logic [NGRP-1:0]  grp_act
);
  logic [SW-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step   <= '0;
      num_q  <= '0;
      mask_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        step   <= '0;
        num_q  <= cmd_num_in;
        mask_q <= cmd_mask_in;
      end
    end else if (step == SW'(NGRP)) begin
      busy <= 1'b0;
    end else begin
      step <= step + 1'b1;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_act
    assign grp_act[g] = busy && (step == SW'(g + 1));
  end

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R2
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst) (busy && step == SW'(NGRP)) |=> !busy); // R2
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst) busy |=> ($stable(num_q) && $stable(mask_q))); // R10
  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (rst) $onehot0(grp_act)); // R3
endmodule

// File: rtl/can_msgobj_xfer.sv
module can_msgobj_xfer
  import can_xfer_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int NUM_W   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int IDXW  = $clog2(NUM_OBJ);
  localparam int WW    = 2 * DW;
  localparam int NSTG  = 9;

  logic [NSTG-1:0][DW-1:0] stg;
  logic [7:0]              cmsk_r;
  logic                    busy;
  logic [NUM_W-1:0]        num_q;
  logic [7:0]              mask_q;
  logic [NGRP-1:0]         grp_act, grp_sel, grp_we, grp_ld;
  logic [NGRP-1:0][WW-1:0] grp_wdata, grp_rdata, stg_grp;
  logic [IDXW-1:0]         obj_idx;
  logic [NUM_OBJ-1:0]      val_bits, nd_bits;
  logic [WW-1:0]           val_map, nd_map;
  logic [DW-1:0]           ctrl_mod;
  logic                    host_ok, wr_dir, start;

  assign host_ok = reg_wr && !busy;
  assign start   = reg_wr && (reg_addr == RA_CREQ);
  assign wr_dir  = mask_q[CM_WR];
  assign obj_idx = num_q[IDXW-1:0];

  can_xfer_seq #(.NUM_W(NUM_W), .NGRP(NGRP)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_mask_in(cmsk_r),
    .cmd_num_in(reg_wdata[NUM_W-1:0]), .busy(busy), .num_q(num_q),
    .mask_q(mask_q), .grp_act(grp_act)
  );

  // Group select bits from the latched command mask
  assign grp_sel[G_MASK] = mask_q[CM_MASK];
  assign grp_sel[G_ARB]  = mask_q[CM_ARB];
  assign grp_sel[G_CTRL] = mask_q[CM_CTRL];
  assign grp_sel[G_DA]   = mask_q[CM_DA];
  assign grp_sel[G_DB]   = mask_q[CM_DB];

  always_comb begin
    stg_grp[G_MASK] = {stg[RA_MSK_HI], stg[RA_MSK_LO]};
    stg_grp[G_ARB]  = {stg[RA_ARB_HI], stg[RA_ARB_LO]};
    stg_grp[G_CTRL] = {{DW{1'b0}}, stg[RA_CTRL]};
    stg_grp[G_DA]   = {stg[RA_DA_HI], stg[RA_DA_LO]};
    stg_grp[G_DB]   = {stg[RA_DB_HI], stg[RA_DB_LO]};
  end

  // Write path into RAM; control uses read-modify-write for flag side effects
  always_comb begin
    grp_we    = grp_act & grp_sel & {NGRP{wr_dir}};
    grp_wdata = stg_grp;
    grp_ld    = grp_act & grp_sel & {NGRP{!wr_dir}};
    if (wr_dir) begin
      ctrl_mod = grp_sel[G_CTRL] ? stg[RA_CTRL] : grp_rdata[G_CTRL][DW-1:0];
      if (mask_q[CM_AUX]) ctrl_mod[CT_TXRQ] = 1'b1;
      grp_we[G_CTRL] = grp_act[G_CTRL] && (grp_sel[G_CTRL] || mask_q[CM_AUX]);
    end else begin
      ctrl_mod = grp_rdata[G_CTRL][DW-1:0];
      if (mask_q[CM_CLRINT]) ctrl_mod[CT_INTPND] = 1'b0;
      if (mask_q[CM_AUX])    ctrl_mod[CT_NEWDAT] = 1'b0;
      grp_we[G_CTRL] = grp_act[G_CTRL] && (mask_q[CM_CLRINT] || mask_q[CM_AUX]);
    end
    grp_wdata[G_CTRL] = {{DW{1'b0}}, ctrl_mod};
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_ram
    localparam int GW = (g == G_CTRL) ? DW : WW;
    can_obj_ram #(.W(GW), .DEPTH(NUM_OBJ)) u_ram (
      .clk(clk), .we(grp_we[g]), .addr(obj_idx),
      .wdata(grp_wdata[g][GW-1:0]), .rdata(grp_rdata[g][GW-1:0])
    );
    if (GW < WW) begin : g_pad
      assign grp_rdata[g][WW-1:GW] = '0;
    end
  end

  can_obj_bitmap #(.NUM_OBJ(NUM_OBJ)) u_val (
    .clk(clk), .rst(rst), .upd(grp_we[G_ARB]), .idx(obj_idx),
    .val(grp_wdata[G_ARB][DW + AR_MSGVAL]), .bits(val_bits)
  );

  can_obj_bitmap #(.NUM_OBJ(NUM_OBJ)) u_nd (
    .clk(clk), .rst(rst), .upd(grp_we[G_CTRL]), .idx(obj_idx),
    .val(grp_wdata[G_CTRL][CT_NEWDAT]), .bits(nd_bits)
  );

  // Staging and command mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      stg    <= '0;
      cmsk_r <= '0;
    end else if (host_ok) begin
      if (reg_addr < AW'(NSTG)) stg[reg_addr] <= reg_wdata;
      if (reg_addr == RA_CMASK) cmsk_r <= reg_wdata[7:0];
    end else begin
      if (grp_ld[G_MASK]) {stg[RA_MSK_HI], stg[RA_MSK_LO]} <= grp_rdata[G_MASK];
      if (grp_ld[G_ARB])  {stg[RA_ARB_HI], stg[RA_ARB_LO]} <= grp_rdata[G_ARB];
      if (grp_ld[G_CTRL]) stg[RA_CTRL] <= grp_rdata[G_CTRL][DW-1:0];
      if (grp_ld[G_DA])   {stg[RA_DA_HI], stg[RA_DA_LO]} <= grp_rdata[G_DA];
      if (grp_ld[G_DB])   {stg[RA_DB_HI], stg[RA_DB_LO]} <= grp_rdata[G_DB];
    end
  end

  always_comb begin
    val_map = '0;
    nd_map  = '0;
    val_map[NUM_OBJ-1:0] = val_bits;
    nd_map[NUM_OBJ-1:0]  = nd_bits;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr < AW'(NSTG)) begin
      reg_rdata <= stg[reg_addr];
    end else begin
      case (reg_addr)
        RA_CMASK:  reg_rdata <= {{(DW-8){1'b0}}, cmsk_r};
        RA_CREQ:   reg_rdata <= {busy, {(DW-1-NUM_W){1'b0}}, num_q};
        RA_VAL_LO: reg_rdata <= val_map[DW-1:0];
        RA_VAL_HI: reg_rdata <= val_map[WW-1:DW];
        RA_ND_LO:  reg_rdata <= nd_map[DW-1:0];
        RA_ND_HI:  reg_rdata <= nd_map[WW-1:DW];
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_RAM_WE_BUSY: assert property (@(posedge clk) disable iff (rst) (|grp_we) |-> busy); // R3
  AST_STG_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && (wr_dir || mask_q == 8'h00)) |=> $stable(stg)); // R10
  AST_VAL_FOLLOW: assert property (@(posedge clk) disable iff (rst) grp_we[G_ARB] |=> (val_bits[$past(obj_idx)] == $past(grp_wdata[G_ARB][DW + AR_MSGVAL]))); // R8
  AST_ND_CLEAR: assert property (@(posedge clk) disable iff (rst) (grp_act[G_CTRL] && !wr_dir && mask_q[CM_AUX]) |=> !nd_bits[$past(obj_idx)]); // R7
  AST_TXRQ_SET: assert property (@(posedge clk) disable iff (rst) (grp_act[G_CTRL] && wr_dir && mask_q[CM_AUX]) |-> (grp_we[G_CTRL] && grp_wdata[G_CTRL][CT_TXRQ])); // R5
endmodule

// File: tb/sim_can_msgobj_xfer.sv
module sim_can_msgobj_xfer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_msgobj_xfer u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic cmd(input logic [7:0] m, input logic [5:0] n);
    wr(4'd9, {8'h00, m});
    wr(4'd10, {10'h000, n});
    repeat (8) @(negedge clk);
  endtask

  task automatic set_stage(input logic [15:0] w [9]);
    for (int i = 0; i < 9; i++) wr(4'(i), w[i]);
  endtask

  task automatic t_reset;
    rd_chk("R1 creq", 4'd10, 16'h0000);
    rd_chk("R1 cmask", 4'd9, 16'h0000);
    for (int a = 11; a <= 14; a++) rd_chk("R1 summary", 4'(a), 16'h0000);
  endtask

  task automatic t_busy;
    wr(4'd9, 16'h0000);
    wr(4'd10, 16'h0003);
    for (int k = 1; k <= 6; k++) rd_chk("R2 busy high", 4'd10, 16'h8003);
    rd_chk("R2 busy low", 4'd10, 16'h0003);
  endtask

  task automatic t_write_full;
    logic [15:0] w [9];
    logic [15:0] z [9];
    w = '{16'h1234, 16'hC0AB, 16'h0F0F, 16'h1F00, 16'h9088,
          16'h2211, 16'h4433, 16'h6655, 16'h8877};
    z = '{default: 16'h0000};
    set_stage(w);
    cmd(8'hF3, 6'd5);
    set_stage(z);
    cmd(8'h73, 6'd5);
    for (int i = 0; i < 9; i++) rd_chk("R3/R4 full copy", 4'(i), w[i]);
    rd_chk("R8 valid lo", 4'd11, 16'h0020);
    rd_chk("R9 newdata lo", 4'd13, 16'h0020);
  endtask

  task automatic t_partial_write;
    logic [15:0] z [9];
    z = '{default: 16'h0000};
    wr(4'd5, 16'hAAAA);
    wr(4'd6, 16'hBBBB);
    wr(4'd0, 16'h5555);
    cmd(8'h82, 6'd5);
    set_stage(z);
    cmd(8'h73, 6'd5);
    rd_chk("R3 arb kept", 4'd0, 16'h1234);
    rd_chk("R3 dataA lo written", 4'd5, 16'hAAAA);
    rd_chk("R3 dataA hi written", 4'd6, 16'hBBBB);
    rd_chk("R3 dataB kept", 4'd7, 16'h6655);
  endtask

  task automatic t_partial_read;
    wr(4'd5, 16'h0101);
    wr(4'd7, 16'h0202);
    wr(4'd8, 16'h0303);
    cmd(8'h01, 6'd5);
    rd_chk("R4 dataB lo loaded", 4'd7, 16'h6655);
    rd_chk("R4 dataB hi loaded", 4'd8, 16'h8877);
    rd_chk("R4 dataA untouched", 4'd5, 16'h0101);
  endtask

  task automatic t_txrq;
    wr(4'd4, 16'h0005);
    cmd(8'h90, 6'd7);
    wr(4'd4, 16'h0000);
    cmd(8'h84, 6'd7);
    rd_chk("R5 stage not loaded", 4'd4, 16'h0000);
    cmd(8'h10, 6'd7);
    rd_chk("R5 txrq set", 4'd4, 16'h0105);
  endtask

  task automatic t_clear_flags;
    wr(4'd4, 16'hA008);
    cmd(8'h90, 6'd9);
    rd_chk("R9 newdata obj9", 4'd13, 16'h0220);
    wr(4'd4, 16'h0000);
    cmd(8'h1C, 6'd9);
    rd_chk("R6 pre-clear value", 4'd4, 16'hA008);
    wr(4'd4, 16'h0000);
    cmd(8'h10, 6'd9);
    rd_chk("R6/R7 flags cleared", 4'd4, 16'h0008);
    rd_chk("R7 summary cleared", 4'd13, 16'h0020);
  endtask

  task automatic t_high_half;
    wr(4'd1, 16'h8000);
    cmd(8'hA0, 6'd20);
    rd_chk("R8 valid hi", 4'd12, 16'h0010);
    rd_chk("R8 valid lo kept", 4'd11, 16'h0020);
    wr(4'd1, 16'h0000);
    cmd(8'hA0, 6'd5);
    rd_chk("R8 valid cleared", 4'd11, 16'h0000);
    rd_chk("R9 newdata hi empty", 4'd14, 16'h0000);
  endtask

  task automatic t_ignored;
    wr(4'd5, 16'h1111);
    wr(4'd9, 16'h0000);
    wr(4'd10, 16'h000B);
    wr(4'd5, 16'hDEAD);
    wr(4'd9, 16'h00FF);
    wr(4'd10, 16'h000C);
    repeat (8) @(negedge clk);
    rd_chk("R10 command ignored", 4'd10, 16'h000B);
    rd_chk("R10 staging write ignored", 4'd5, 16'h1111);
    rd_chk("R10 mask write ignored", 4'd9, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_busy();
    t_write_full();
    t_partial_write();
    t_partial_read();
    t_txrq();
    t_clear_flags();
    t_high_half();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-R10 run actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule